// File: doc/BRIEF.md
# Inverted-Gray Xorshift-Rotate Random Word Generator

This block produces a stream of 16-bit pseudo-random words from 32 bits of internal state held as two 16-bit words. Every cycle in which the step strobe is high, the block registers a new output word and advances its state by one iteration. The output word is scrambled from the state as it stood *before* that iteration. The state update is a xorshift-rotate engine. In place of the usual left-shifted term, it mixes in an inverted Gray code of the xor of the two state words: the complement of that xor, xored with the xor shifted by one place. The scrambler adds the two state words, rotates the sum left, and adds the first word again.

A seed-load input replaces the state with two caller-supplied words. An all-zero seed is replaced by the reset state. Loading a seed does not touch the output register. Parameters set the three engine constants, the scrambler rotation, and the shift direction of the Gray term. This allows the left-shift variant of the engine to be built from the same source.

Top module: `xgray_rng`

## Requirements
- R1: After a synchronous reset, `rnd_out` reads 0 and the state is first word 1, second word 0. The first step after reset therefore yields 16'h0201.
- R2: On a step, the new first state word is rotl(s0, ROT_A) xor (not t) xor (t >> SHIFT_B), where t = s0 xor s1. Rotations are left rotations on 16-bit words.
- R3: On a step, the new second state word is rotl(t, ROT_C). With defaults ROT_A=5, SHIFT_B=1, ROT_C=14 and ROT_D=9, the output sequence from reset follows R2 to R4 exactly.
- R4: On a step, `rnd_out` takes rotl(s0 + s1, ROT_D) + s0 (sums modulo 2^16), computed from the state before the update, on the same clock edge as the state change.
- R5: With both `step` and `seed_load` low, the state and `rnd_out` hold their values.
- R6: With `seed_load` high, the state becomes (`seed_s0`, `seed_s1`) and `rnd_out` holds, whether or not `step` is also high.
- R7: A seed load with both seed words zero sets the state to first word 1, second word 0. The next step therefore yields 16'h0201.
- R8: An all-zero state is not a trap. From the seed (16'hFFFF, 16'hFFFF), three steps yield 16'hFDFE, 16'h0000 and 16'hFFFE.
- R9: With SHIFT_RIGHT=0, the Gray term uses (t << SHIFT_B) instead of (t >> SHIFT_B). All other behaviour is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance one iteration and register a new output word |
| seed_load | input | 1 | Replace the state with the seed words; has priority over step |
| seed_s0 | input | 16 | Seed for the first state word |
| seed_s1 | input | 16 | Seed for the second state word |
| rnd_out | output | 16 | Registered scrambled output word |

## Verification
The checker watches every cycle for the reset values of state and output. It also checks that state and output hold in idle cycles, that a seed load lands as the state with the output held, that a zero seed is replaced, and that the second state word follows the rotated xor of the previous state. The first-word Gray-code mixing and the add-rotate-add scrambler appear only in the word stream. The bench compares that stream against its own arithmetic model over thousands of steps and hundreds of seeds. A second instance built for left shifts confirms the other variant. The escape from the all-zero state is shown only by the bench's fixed sequence.

// File: rtl/xgray_pkg.sv
package xgray_pkg;

    parameter int unsigned WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t s0;
        word_t s1;
    } xg_state_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } xg_op_e;

    localparam xg_state_t RESET_STATE = '{s0: word_t'(1), s1: '0};

    function automatic word_t rotl(word_t v, int unsigned k);
        int unsigned r;
        r = k % WORD_W;
        if (r == 0) begin
            return v;
        end
        return (v << r) | (v >> (WORD_W - r));
    endfunction

    function automatic xg_state_t sanitize_seed(xg_state_t seed);
        if (seed == '0) begin
            return RESET_STATE;
        end
        return seed;
    endfunction

endpackage

// File: rtl/xg_engine.sv
module xg_engine
    import xgray_pkg::*;
#(
    parameter int unsigned ROT_A       = 5,
    parameter int unsigned SHIFT_B     = 1,
    parameter int unsigned ROT_C       = 14,
    parameter bit          SHIFT_RIGHT = 1'b1
) (
    input  xg_state_t cur,
    output xg_state_t nxt
);
    word_t mix_t;
    word_t shifted_t;
    word_t gray_t;

    assign mix_t = cur.s0 ^ cur.s1;

    generate
        if (SHIFT_RIGHT) begin : g_shr
            assign shifted_t = mix_t >> SHIFT_B;
        end else begin : g_shl
            assign shifted_t = mix_t << SHIFT_B;
        end
    endgenerate

    assign gray_t = ~mix_t ^ shifted_t;

    always_comb begin
        nxt.s0 = rotl(cur.s0, ROT_A) ^ gray_t;
        nxt.s1 = rotl(mix_t, ROT_C);
    end
endmodule

// File: rtl/xg_scrambler.sv
module xg_scrambler
    import xgray_pkg::*;
#(
    parameter int unsigned ROT_D = 9
) (
    input  xg_state_t cur,
    output word_t     prn
);
    word_t pair_sum;
    word_t turned;

    assign pair_sum = cur.s0 + cur.s1;
    assign turned   = rotl(pair_sum, ROT_D);
    assign prn      = turned + cur.s0;
endmodule

// File: rtl/xg_state_reg.sv
module xg_state_reg
    import xgray_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  xg_op_e    op,
    input  xg_state_t seed,
    input  xg_state_t nxt,
    output xg_state_t cur
);
    xg_state_t clean_seed;

    assign clean_seed = sanitize_seed(seed);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= RESET_STATE;
        end else begin
            unique case (op)
                OP_LOAD: cur <= clean_seed;
                OP_STEP: cur <= nxt;
                default: cur <= cur;
            endcase
        end
    end
endmodule

// File: rtl/xgray_rng.sv
module xgray_rng
    import xgray_pkg::*;
#(
    parameter int unsigned ROT_A       = 5,
    parameter int unsigned SHIFT_B     = 1,
    parameter int unsigned ROT_C       = 14,
    parameter int unsigned ROT_D       = 9,
    parameter bit          SHIFT_RIGHT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              seed_load,
    input  logic [WORD_W-1:0] seed_s0,
    input  logic [WORD_W-1:0] seed_s1,
    output logic [WORD_W-1:0] rnd_out
);
    xg_op_e    op;
    xg_state_t cur_state;
    xg_state_t nxt_state;
    xg_state_t seed_pair;
    word_t     prn_word;
    word_t     rnd_q;
    word_t     state_s0;
    word_t     state_s1;

    always_comb begin
        if (seed_load) begin
            op = OP_LOAD;
        end else if (step) begin
            op = OP_STEP;
        end else begin
            op = OP_IDLE;
        end
    end

    assign seed_pair = '{s0: seed_s0, s1: seed_s1};

    xg_engine #(
        .ROT_A      (ROT_A),
        .SHIFT_B    (SHIFT_B),
        .ROT_C      (ROT_C),
        .SHIFT_RIGHT(SHIFT_RIGHT)
    ) u_engine (
        .cur(cur_state),
        .nxt(nxt_state)
    );

    xg_scrambler #(
        .ROT_D(ROT_D)
    ) u_scrambler (
        .cur(cur_state),
        .prn(prn_word)
    );

    xg_state_reg u_state (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .seed(seed_pair),
        .nxt (nxt_state),
        .cur (cur_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rnd_q <= '0;
        end else if (op == OP_STEP) begin
            rnd_q <= prn_word;
        end
    end

    assign state_s0 = cur_state.s0;
    assign state_s1 = cur_state.s1;
    assign rnd_out  = rnd_q;
endmodule

// File: rtl/xgray_rng_chk.sv
module xgray_rng_chk
    import xgray_pkg::*;
#(
    parameter int unsigned ROT_C = 14
) (
    input logic  clk,
    input logic  rst,
    input logic  step,
    input logic  seed_load,
    input word_t seed_s0,
    input word_t seed_s1,
    input word_t st_s0,
    input word_t st_s1,
    input word_t rnd_out
);
    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_s0 == word_t'(1) && st_s1 == '0 && rnd_out == '0)); // R1

    AST_S1_FOLLOWS_XOR: assert property (@(posedge clk) disable iff (rst)
        (step && !seed_load) |=> st_s1 == rotl($past(st_s0 ^ st_s1), ROT_C)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!step && !seed_load) |=> ($stable(st_s0) && $stable(st_s1) && $stable(rnd_out))); // R5

    AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (seed_load && (seed_s0 != '0 || seed_s1 != '0)) |=>
            (st_s0 == $past(seed_s0) && st_s1 == $past(seed_s1))); // R6

    AST_SEED_KEEPS_OUT: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> $stable(rnd_out)); // R6

    AST_ZERO_SEED_FORCED: assert property (@(posedge clk) disable iff (rst)
        (seed_load && seed_s0 == '0 && seed_s1 == '0) |=>
            (st_s0 == word_t'(1) && st_s1 == '0)); // R7
endmodule

bind xgray_rng xgray_rng_chk #(.ROT_C(ROT_C)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .seed_load(seed_load),
    .seed_s0  (seed_s0),
    .seed_s1  (seed_s1),
    .st_s0    (state_s0),
    .st_s1    (state_s1),
    .rnd_out  (rnd_out)
);

// File: tb/xgray_rng_test.sv
module xgray_rng_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed_s0 = '0;
    logic [15:0] seed_s1 = '0;
    logic [15:0] out_r;
    logic [15:0] out_l;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] r_s0, r_s1, r_out;
    logic [15:0] l_s0, l_s1, l_out;

    always #10 clk = ~clk;

    xgray_rng uut (
        .clk(clk), .rst(rst), .step(step), .seed_load(seed_load),
        .seed_s0(seed_s0), .seed_s1(seed_s1), .rnd_out(out_r)
    );

    xgray_rng #(.SHIFT_RIGHT(1'b0)) uut_lft (
        .clk(clk), .rst(rst), .step(step), .seed_load(seed_load),
        .seed_s0(seed_s0), .seed_s1(seed_s1), .rnd_out(out_l)
    );

    function automatic logic [15:0] rl(logic [15:0] v, int k);
        return (k == 0) ? v : ((v << k) | (v >> (16 - k)));
    endfunction

    task automatic model_step(inout logic [15:0] a, inout logic [15:0] b,
                              inout logic [15:0] o, input bit right);
        logic [15:0] t;
        logic [15:0] sum;
        sum = a + b;
        o = rl(sum, 9) + a;
        t = a ^ b;
        a = rl(a, 5) ^ ~t ^ (right ? (t >> 1) : (t << 1));
        b = rl(t, 14);
    endtask

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic models_reset();
        r_s0 = 16'd1; r_s1 = '0; r_out = '0;
        l_s0 = 16'd1; l_s1 = '0; l_out = '0;
    endtask

    // Called at a falling edge; drives inputs, waits one cycle, updates models, checks.
    task automatic cycle(bit nx, bit ld, logic [15:0] a, logic [15:0] b, string req);
        step = nx; seed_load = ld; seed_s0 = a; seed_s1 = b;
        @(negedge clk);
        if (ld) begin
            if (a == '0 && b == '0) begin
                r_s0 = 16'd1; r_s1 = '0; l_s0 = 16'd1; l_s1 = '0;
            end else begin
                r_s0 = a; r_s1 = b; l_s0 = a; l_s1 = b;
            end
        end else if (nx) begin
            model_step(r_s0, r_s1, r_out, 1'b1);
            model_step(l_s0, l_s1, l_out, 1'b0);
        end
        check(req, out_r, r_out);
        check({req, " R9 left variant"}, out_l, l_out);
        step = 1'b0; seed_load = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step = 1'b0; seed_load = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        models_reset();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset output", out_r, 16'h0000);
        check("R1 reset output left", out_l, 16'h0000);
        cycle(1'b1, 1'b0, '0, '0, "R1 first step");
        check("R1 first word", out_r, 16'h0201);

        // long run from reset with idle cycles interleaved
        for (int i = 0; i < 3000; i++) begin
            if (i % 7 == 3) begin
                cycle(1'b0, 1'b0, 16'hA5A5, 16'h5A5A, "R5 idle hold");
            end else begin
                cycle(1'b1, 1'b0, '0, '0, "R2 R3 R4 step");
            end
        end

        // seed sweep; load alone, load with step, then steps
        for (int i = 0; i < 256; i++) begin
            logic [15:0] a;
            logic [15:0] b;
            a = 16'(i * 257) ^ 16'h1234;
            b = 16'(~(i * 73));
            cycle(1'b0, 1'b1, a, b, "R6 seed load output holds");
            for (int j = 0; j < 3; j++) cycle(1'b1, 1'b0, '0, '0, "R2 R3 R4 seeded");
            cycle(1'b1, 1'b1, b, a, "R6 load beats step");
            for (int j = 0; j < 3; j++) cycle(1'b1, 1'b0, '0, '0, "R2 R3 R4 seeded");
        end

        // zero seed is replaced
        cycle(1'b0, 1'b1, '0, '0, "R7 zero seed load");
        cycle(1'b1, 1'b0, '0, '0, "R7 zero seed step");
        check("R7 zero seed word", out_r, 16'h0201);

        // escape from all-zero state
        cycle(1'b0, 1'b1, 16'hFFFF, 16'hFFFF, "R8 all-ones seed");
        cycle(1'b1, 1'b0, '0, '0, "R8 step into zero");
        check("R8 word one", out_r, 16'hFDFE);
        cycle(1'b1, 1'b0, '0, '0, "R8 step from zero");
        check("R8 word two", out_r, 16'h0000);
        cycle(1'b1, 1'b0, '0, '0, "R8 escaped");
        check("R8 word three", out_r, 16'hFFFE);
        check("R8 word three left R9", out_l, 16'hFFFE);

        // reset in mid-run
        for (int j = 0; j < 5; j++) cycle(1'b1, 1'b0, '0, '0, "R2 R3 R4 pre-reset");
        do_reset();
        check("R1 mid-run reset output", out_r, 16'h0000);
        cycle(1'b1, 1'b0, '0, '0, "R1 step after reset");
        check("R1 word after reset", out_r, 16'h0201);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule